// File: doc/BRIEF.md
# UART FIFO and Status Controller

This block sits between an 8-bit register bus and the serial frame engine of a UART. It owns the transmit and receive queues, reports their sizes as encoded exponents, exposes their occupancy and programmable thresholds, and keeps the line-status view that software polls. Software pushes characters by writing the data register and pulls received characters by reading it. The frame engine takes transmit characters from a valid/take handshake and delivers received characters, each with its noise, framing and parity flags, on a single-cycle strobe.

Three level outputs summarise the queues. The transmit request is high while transmit occupancy is at or below its threshold. The receive request is high while receive occupancy is nonzero and at or above its threshold. The transmission-complete output is high only once the queue is empty and the shifter reports idle. Line error flags follow a two-step clearing rule: a status read followed directly by a data read clears them. Queue overflow and underflow events are recorded in a separate event register and cleared by writing ones.

Top module: `uart_fifo_ctrl`

Register offsets: 0 line status, 1 data, 2 queue parameters, 3 queue control, 4 queue events, 5 transmit threshold, 6 transmit count, 7 receive threshold, 8 receive count. Bus reads are combinational from the address. Side effects of a read take place at the clock edge where the read enable is high.

## Requirements
- R1: After reset both counts are 0, the transmit threshold is 0 and the receive threshold is 1. The line status reads 0xC0 and the queue event register reads 0xC0.
- R2: The queue parameter register holds the transmit depth code in bits 6:4 and the receive depth code in bits 2:0. A code n means 2^(n+1) entries. Bit 7 enables the transmit queue and bit 3 enables the receive queue; both reset to enabled. A disabled queue holds a single entry.
- R3: Data register writes enter the transmit queue and reach the frame engine in write order. The transmit count register reports the number of occupied entries.
- R4: A data write to a full transmit queue is discarded. If queue control bit 1 is set, the write also sets queue event bit 1.
- R5: Received characters are read from the data register in arrival order, and the receive count register reports occupancy. A character arriving at a full receive queue is discarded and sets the overrun flag (line status bit 3). If queue control bit 2 is set, it also sets queue event bit 2.
- R6: A data read while the receive queue is empty sets queue event bit 0 when queue control bit 0 is set.
- R7: Queue event bits 2:0 clear when 1 is written to them. Bit 7 reads 1 when the transmit queue is empty, and bit 6 reads 1 when the receive queue is empty.
- R8: Writing queue control with bit 7 set empties the transmit queue. Writing it with bit 6 set empties the receive queue.
- R9: `tx_req_o` and line status bit 7 are high exactly while transmit count is at or below the transmit threshold.
- R10: `rx_req_o` and line status bit 5 are high exactly while receive count is nonzero and at or above the receive threshold.
- R11: `tx_done_o` and line status bit 6 are high only while the transmit queue is empty and `tx_busy_i` is low.
- R12: Line status bits 2, 1 and 0 show the noise, framing and parity flags stored with the character at the head of the receive queue.
- R13: A data read directly preceded by a line status read clears overrun and any retained error flags. A data read with no such preceding status read leaves the overrun flag set, and the removed character's error flags stay visible in line status until a proper clearing sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 4 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on edge) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| tx_char_o | output | 8 | Transmit queue head character |
| tx_valid_o | output | 1 | Transmit queue holds a character |
| tx_take_i | input | 1 | Frame engine removes the head character |
| tx_busy_i | input | 1 | Shifter still sending |
| rx_char_i | input | 8 | Received character |
| rx_err_i | input | 3 | Noise, framing, parity flags (bit 2..0) |
| rx_stb_i | input | 1 | Received character strobe |
| tx_req_o | output | 1 | Transmit threshold request |
| tx_done_o | output | 1 | Transmission complete |
| rx_req_o | output | 1 | Receive threshold request |

## Verification
The bench builds the block with both queues four entries deep. At that depth, a handful of bus accesses fills either queue, so the overflow, overrun and dropped-character paths can all be driven. Depth code 1 can be checked in the parameter register. The single-entry disabled mode and the threshold crossings both fall within short sequences. The clearing rule is exercised with armed and unarmed data reads against a four-character queue that carries distinct error flags.

// File: rtl/uart_fifo_pkg.sv
`timescale 1ns/1ps
package uart_fifo_pkg;

   typedef enum logic [3:0] {
      RA_STAT  = 4'd0,
      RA_DATA  = 4'd1,
      RA_FPARM = 4'd2,
      RA_FCTRL = 4'd3,
      RA_FSTAT = 4'd4,
      RA_TXWM  = 4'd5,
      RA_TXCNT = 4'd6,
      RA_RXWM  = 4'd7,
      RA_RXCNT = 4'd8
   } reg_addr_e;

   // queue parameter register bit positions
   localparam int FP_TX_EN  = 7;
   localparam int FP_RX_EN  = 3;
   // queue control register bit positions
   localparam int FC_TX_FLUSH = 7;
   localparam int FC_RX_FLUSH = 6;
   localparam int FC_RXOF_EN  = 2;
   localparam int FC_TXOF_EN  = 1;
   localparam int FC_RXUF_EN  = 0;

   localparam int ERR_W = 3;

   typedef struct packed {
      logic noise;
      logic frame;
      logic parity;
   } rx_err_t;

   typedef struct packed {
      rx_err_t    err;
      logic [7:0] ch;
   } rx_entry_t;

   function automatic logic [2:0] depth_code(input int depth);
      return 3'($clog2(depth) - 1);
   endfunction

endpackage

// File: rtl/uart_sfifo.sv
`timescale 1ns/1ps
module uart_sfifo #(
   parameter  int WIDTH = 8,
   parameter  int DEPTH = 16,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic [CW-1:0]    limit_i,
   input  logic             push_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic [CW-1:0]    count_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             ovf_o,
   output logic             unf_o
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             push_ok, pop_ok;

   assign full_o  = (cnt >= limit_i);
   assign empty_o = (cnt == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign ovf_o   = push_i && full_o && !flush_i;
   assign unf_o   = pop_i && empty_o && !flush_i;
   assign count_o = cnt;
   assign head_o  = mem[rp];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush_i) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_ok && !flush_i) mem[wp] <= wdata_i;
   end

endmodule

// File: rtl/uart_w1c_bank.sv
`timescale 1ns/1ps
module uart_w1c_bank #(
   parameter int N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       q <= 1'b0;
         else if (set_i[g]) q <= 1'b1;
         else if (clr_i[g]) q <= 1'b0;
      end
      assign flags_o[g] = q;
   end

endmodule

// File: rtl/uart_stat_track.sv
`timescale 1ns/1ps
module uart_stat_track
   import uart_fifo_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       stat_rd_i,
   input  logic       data_rd_i,
   input  logic       other_acc_i,
   input  rx_err_t    head_err_i,
   input  logic       rx_empty_i,
   input  logic       overrun_evt_i,
   output logic [3:0] view_o
);

   logic    armed;
   logic    ovr;
   rx_err_t kept;
   rx_err_t head_vis;

   assign head_vis = rx_empty_i ? rx_err_t'('0) : head_err_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed <= 1'b0;
         ovr   <= 1'b0;
         kept  <= '0;
      end else begin
         if (stat_rd_i)                    armed <= 1'b1;
         else if (data_rd_i || other_acc_i) armed <= 1'b0;

         if (data_rd_i) begin
            if (armed) kept <= '0;
            else       kept <= kept | head_vis;
         end

         if (overrun_evt_i)         ovr <= 1'b1;
         else if (data_rd_i && armed) ovr <= 1'b0;
      end
   end

   assign view_o = {ovr, kept | head_vis};

endmodule

// File: rtl/uart_fifo_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_ctrl
   import uart_fifo_pkg::*;
#(
   parameter int       TX_DEPTH    = 16,
   parameter int       RX_DEPTH    = 16,
   parameter int       TXWM_RST    = 0,
   parameter int       RXWM_RST    = 1,
   parameter bit       FIFO_EN_RST = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [3:0] reg_addr_i,
   input  logic       reg_wr_i,
   input  logic       reg_rd_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   output logic [7:0] tx_char_o,
   output logic       tx_valid_o,
   input  logic       tx_take_i,
   input  logic       tx_busy_i,
   input  logic [7:0] rx_char_i,
   input  logic [2:0] rx_err_i,
   input  logic       rx_stb_i,
   output logic       tx_req_o,
   output logic       tx_done_o,
   output logic       rx_req_o
);

   localparam int TX_CW = $clog2(TX_DEPTH) + 1;
   localparam int RX_CW = $clog2(RX_DEPTH) + 1;
   localparam logic [2:0] TX_CODE = depth_code(TX_DEPTH);
   localparam logic [2:0] RX_CODE = depth_code(RX_DEPTH);
   localparam int RXE_W = $bits(rx_entry_t);

   // elaboration-time parameter checks
   if (TX_DEPTH < 2 || TX_DEPTH > 128 || (TX_DEPTH & (TX_DEPTH - 1)) != 0) begin : g_bad_tx
      $error("TX_DEPTH must be a power of two in 2..128");
   end
   if (RX_DEPTH < 2 || RX_DEPTH > 128 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_bad_rx
      $error("RX_DEPTH must be a power of two in 2..128");
   end
   if (TXWM_RST < 0 || TXWM_RST > 255 || RXWM_RST < 0 || RXWM_RST > 255) begin : g_bad_wm
      $error("watermark reset values must fit in 8 bits");
   end

   // bus decode
   logic wr_data, rd_data, rd_stat, wr_fparm, wr_fctrl, wr_fstat, wr_txwm, wr_rxwm, other_acc;
   assign wr_data  = reg_wr_i && (reg_addr_i == RA_DATA);
   assign rd_data  = reg_rd_i && (reg_addr_i == RA_DATA);
   assign rd_stat  = reg_rd_i && (reg_addr_i == RA_STAT);
   assign wr_fparm = reg_wr_i && (reg_addr_i == RA_FPARM);
   assign wr_fctrl = reg_wr_i && (reg_addr_i == RA_FCTRL);
   assign wr_fstat = reg_wr_i && (reg_addr_i == RA_FSTAT);
   assign wr_txwm  = reg_wr_i && (reg_addr_i == RA_TXWM);
   assign wr_rxwm  = reg_wr_i && (reg_addr_i == RA_RXWM);
   assign other_acc = reg_wr_i || (reg_rd_i && !rd_data && !rd_stat);

   // configuration registers
   logic       tx_fen, rx_fen;
   logic       rxof_en, txof_en, rxuf_en;
   logic [7:0] txwm, rxwm;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_fen  <= FIFO_EN_RST;
         rx_fen  <= FIFO_EN_RST;
         rxof_en <= 1'b0;
         txof_en <= 1'b0;
         rxuf_en <= 1'b0;
         txwm    <= 8'(TXWM_RST);
         rxwm    <= 8'(RXWM_RST);
      end else begin
         if (wr_fparm) begin
            tx_fen <= reg_wdata_i[FP_TX_EN];
            rx_fen <= reg_wdata_i[FP_RX_EN];
         end
         if (wr_fctrl) begin
            rxof_en <= reg_wdata_i[FC_RXOF_EN];
            txof_en <= reg_wdata_i[FC_TXOF_EN];
            rxuf_en <= reg_wdata_i[FC_RXUF_EN];
         end
         if (wr_txwm) txwm <= reg_wdata_i;
         if (wr_rxwm) rxwm <= reg_wdata_i;
      end
   end

   // transmit queue
   logic [TX_CW-1:0] tx_cap, tx_cnt;
   logic             tx_full, tx_empty, tx_ovf, unused_tx_unf;
   assign tx_cap = tx_fen ? TX_CW'(TX_DEPTH) : TX_CW'(1);

   uart_sfifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (wr_fctrl && reg_wdata_i[FC_TX_FLUSH]),
      .limit_i (tx_cap),
      .push_i  (wr_data),
      .wdata_i (reg_wdata_i),
      .pop_i   (tx_take_i),
      .head_o  (tx_char_o),
      .count_o (tx_cnt),
      .full_o  (tx_full),
      .empty_o (tx_empty),
      .ovf_o   (tx_ovf),
      .unf_o   (unused_tx_unf)
   );

   // receive queue
   logic [RX_CW-1:0] rx_cap, rx_cnt;
   logic             rx_full, rx_empty, rx_ovf, rx_unf;
   rx_entry_t        rx_in, rx_head;
   logic [RXE_W-1:0] rx_head_bits;
   assign rx_cap  = rx_fen ? RX_CW'(RX_DEPTH) : RX_CW'(1);
   assign rx_in   = '{err: rx_err_t'(rx_err_i), ch: rx_char_i};
   assign rx_head = rx_entry_t'(rx_head_bits);

   uart_sfifo #(.WIDTH(RXE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (wr_fctrl && reg_wdata_i[FC_RX_FLUSH]),
      .limit_i (rx_cap),
      .push_i  (rx_stb_i),
      .wdata_i (rx_in),
      .pop_i   (rd_data),
      .head_o  (rx_head_bits),
      .count_o (rx_cnt),
      .full_o  (rx_full),
      .empty_o (rx_empty),
      .ovf_o   (rx_ovf),
      .unf_o   (rx_unf)
   );

   logic unused_full;
   assign unused_full = tx_full ^ rx_full;

   // queue event flags (write one to clear)
   logic [2:0] ev_set, ev_clr, ev_flags;
   assign ev_set = {rx_ovf && rxof_en, tx_ovf && txof_en, rx_unf && rxuf_en};
   assign ev_clr = wr_fstat ? reg_wdata_i[2:0] : 3'b000;

   uart_w1c_bank #(.N(3)) u_ev (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ev_set),
      .clr_i   (ev_clr),
      .flags_o (ev_flags)
   );

   // line status tracking
   logic [3:0] err_view;

   uart_stat_track u_stat (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .stat_rd_i     (rd_stat),
      .data_rd_i     (rd_data),
      .other_acc_i   (other_acc),
      .head_err_i    (rx_head.err),
      .rx_empty_i    (rx_empty),
      .overrun_evt_i (rx_ovf),
      .view_o        (err_view)
   );

   // level indications
   logic [8:0] tx_cnt9, rx_cnt9;
   assign tx_cnt9    = 9'(tx_cnt);
   assign rx_cnt9    = 9'(rx_cnt);
   assign tx_req_o   = (tx_cnt9 <= {1'b0, txwm});
   assign rx_req_o   = !rx_empty && (rx_cnt9 >= {1'b0, rxwm});
   assign tx_done_o  = tx_empty && !tx_busy_i;
   assign tx_valid_o = !tx_empty;

   // read mux
   always_comb begin
      unique case (reg_addr_i)
         RA_STAT:  reg_rdata_o = {tx_req_o, tx_done_o, rx_req_o, 1'b0, err_view};
         RA_DATA:  reg_rdata_o = rx_head.ch;
         RA_FPARM: reg_rdata_o = {tx_fen, TX_CODE, rx_fen, RX_CODE};
         RA_FCTRL: reg_rdata_o = {5'b00000, rxof_en, txof_en, rxuf_en};
         RA_FSTAT: reg_rdata_o = {tx_empty, rx_empty, 3'b000, ev_flags};
         RA_TXWM:  reg_rdata_o = txwm;
         RA_TXCNT: reg_rdata_o = 8'(tx_cnt);
         RA_RXWM:  reg_rdata_o = rxwm;
         RA_RXCNT: reg_rdata_o = 8'(rx_cnt);
         default:  reg_rdata_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_chk
   import uart_fifo_pkg::*;
#(
   parameter int TXC = 5,
   parameter int RXC = 5
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic [3:0]     reg_addr_i,
   input logic           reg_wr_i,
   input logic           reg_rd_i,
   input logic [7:0]     reg_wdata_i,
   input logic           tx_take_i,
   input logic           tx_busy_i,
   input logic           rx_stb_i,
   input logic           tx_done_o,
   input logic           rx_req_o,
   input logic [TXC-1:0] tx_cnt,
   input logic [RXC-1:0] rx_cnt,
   input logic [TXC-1:0] tx_cap,
   input logic [RXC-1:0] rx_cap
);

   logic w_data, r_data, w_fctrl;
   assign w_data  = reg_wr_i && (reg_addr_i == RA_DATA);
   assign r_data  = reg_rd_i && (reg_addr_i == RA_DATA);
   assign w_fctrl = reg_wr_i && (reg_addr_i == RA_FCTRL);

   AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_data && tx_cnt >= tx_cap && !tx_take_i && !w_fctrl) |=> tx_cnt == $past(tx_cnt)); // R4

   AST_RX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_stb_i && rx_cnt >= rx_cap && !r_data && !w_fctrl) |=> rx_cnt == $past(rx_cnt)); // R5

   AST_TX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_fctrl && reg_wdata_i[FC_TX_FLUSH]) |=> tx_cnt == '0); // R8

   AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_fctrl && reg_wdata_i[FC_RX_FLUSH]) |=> rx_cnt == '0); // R8

   AST_DONE_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_busy_i |-> !tx_done_o); // R11

   AST_RXREQ_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_cnt == '0) |-> !rx_req_o); // R10

   AST_TX_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_data && !tx_take_i && !w_fctrl && tx_cnt < tx_cap) |=> tx_cnt == $past(tx_cnt) + 1'b1); // R3

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.TXC(TX_CW), .RXC(RX_CW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_addr_i  (reg_addr_i),
   .reg_wr_i    (reg_wr_i),
   .reg_rd_i    (reg_rd_i),
   .reg_wdata_i (reg_wdata_i),
   .tx_take_i   (tx_take_i),
   .tx_busy_i   (tx_busy_i),
   .rx_stb_i    (rx_stb_i),
   .tx_done_o   (tx_done_o),
   .rx_req_o    (rx_req_o),
   .tx_cnt      (tx_cnt),
   .rx_cnt      (rx_cnt),
   .tx_cap      (tx_cap),
   .rx_cap      (rx_cap)
);

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb;
   import uart_fifo_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic [7:0] tx_char;
   logic       tx_valid, tx_take, tx_busy = 1'b0;
   logic [7:0] rx_char = '0;
   logic [2:0] rx_err = '0;
   logic       rx_stb = 1'b0;
   logic       tx_req, tx_done, rx_req;

   int n_chk = 0, n_fail = 0;
   bit drain = 1'b0;
   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];

   always #5 clk = ~clk;

   uart_fifo_ctrl #(.TX_DEPTH(4), .RX_DEPTH(4)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr_en), .reg_rd_i(rd_en),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_char_o(tx_char), .tx_valid_o(tx_valid),
      .tx_take_i(tx_take), .tx_busy_i(tx_busy), .rx_char_i(rx_char), .rx_err_i(rx_err),
      .rx_stb_i(rx_stb), .tx_req_o(tx_req), .tx_done_o(tx_done), .rx_req_o(rx_req));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(posedge clk); #1 rd_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] mask, input logic [7:0] exp, input string tag);
      logic [7:0] d;
      rd(a, d);
      chk((d & mask) == exp, tag, d & mask, exp);
   endtask

   // driver: push to design and to expected queue (if room)
   task automatic tx_send(input logic [7:0] d, input bit expect_kept);
      if (expect_kept) tx_exp.push_back(d);
      wr(RA_DATA, d);
   endtask

   task automatic rx_send(input logic [7:0] c, input logic [2:0] e, input bit expect_kept);
      if (expect_kept) rx_exp.push_back(c);
      @(negedge clk); rx_char = c; rx_err = e; rx_stb = 1'b1;
      @(posedge clk); #1 rx_stb = 1'b0;
   endtask

   // receive monitor: reads data register and compares to scoreboard
   task automatic rx_take();
      logic [7:0] d, e;
      rd(RA_DATA, d);
      e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 8'hXX;
      chk(d === e, "R5 rx order", d, e);
   endtask

   // transmit monitor: takes characters from the frame-engine side
   initial begin
      tx_take = 1'b0;
      forever begin
         @(negedge clk);
         tx_take = 1'b0;
         if (drain && tx_valid) begin
            logic [7:0] e;
            e = (tx_exp.size() != 0) ? tx_exp.pop_front() : 8'hXX;
            chk(tx_char === e, "R3 tx order", tx_char, e);
            tx_take = 1'b1;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 reset state
      rd_chk(RA_STAT,  8'hFF, 8'hC0, "R1 status");
      rd_chk(RA_FSTAT, 8'hFF, 8'hC0, "R1 events");
      rd_chk(RA_TXCNT, 8'hFF, 8'h00, "R1 txcnt");
      rd_chk(RA_RXCNT, 8'hFF, 8'h00, "R1 rxcnt");
      rd_chk(RA_TXWM,  8'hFF, 8'h00, "R1 txwm");
      rd_chk(RA_RXWM,  8'hFF, 8'h01, "R1 rxwm");
      // R2 depth codes and enables
      rd_chk(RA_FPARM, 8'hFF, 8'h99, "R2 params");

      wr(RA_FCTRL, 8'h07);
      // R3 / R9 / R11 transmit side
      tx_send(8'h11, 1); tx_send(8'h22, 1); tx_send(8'h33, 1);
      rd_chk(RA_TXCNT, 8'hFF, 8'h03, "R3 txcnt");
      chk(tx_req == 1'b0, "R9 above wm", tx_req, 0);
      chk(tx_done == 1'b0, "R11 queue busy", tx_done, 0);
      wr(RA_TXWM, 8'h03);
      chk(tx_req == 1'b1, "R9 at wm", tx_req, 1);
      rd_chk(RA_STAT, 8'h80, 8'h80, "R9 status bit");
      tx_send(8'h44, 1);
      chk(tx_req == 1'b0, "R9 over wm", tx_req, 0);
      tx_send(8'hEE, 0);
      rd_chk(RA_TXCNT, 8'hFF, 8'h04, "R4 count held");
      rd_chk(RA_FSTAT, 8'hFF, 8'h42, "R4 tx overflow");
      wr(RA_FSTAT, 8'h02);
      rd_chk(RA_FSTAT, 8'hFF, 8'h40, "R7 w1c");
      drain = 1'b1;
      repeat (10) @(posedge clk);
      drain = 1'b0;
      #1;
      chk(tx_exp.size() == 0, "R3 all sent", tx_exp.size(), 0);
      rd_chk(RA_TXCNT, 8'hFF, 8'h00, "R3 drained");
      @(negedge clk); tx_busy = 1'b1; #1;
      chk(tx_done == 1'b0, "R11 shifter busy", tx_done, 0);
      @(negedge clk); tx_busy = 1'b0; #1;
      chk(tx_done == 1'b1, "R11 idle", tx_done, 1);

      // R8 transmit flush
      tx_send(8'h55, 0); tx_send(8'h66, 0);
      wr(RA_FCTRL, 8'h87);
      rd_chk(RA_TXCNT, 8'hFF, 8'h00, "R8 tx flush");

      // R2 disabled queue holds one entry
      wr(RA_FPARM, 8'h08);
      tx_send(8'h77, 0); tx_send(8'h78, 0);
      rd_chk(RA_TXCNT, 8'hFF, 8'h01, "R2 single entry");
      rd_chk(RA_FSTAT, 8'h02, 8'h02, "R2 single overflow");
      wr(RA_FCTRL, 8'h87);
      wr(RA_FSTAT, 8'h07);
      wr(RA_FPARM, 8'h88);

      // R10 / R5 / R12 / R13 receive side
      rx_send(8'hA0, 3'b000, 1);
      chk(rx_req == 1'b1, "R10 wm 1", rx_req, 1);
      wr(RA_RXWM, 8'h03);
      chk(rx_req == 1'b0, "R10 below wm", rx_req, 0);
      rx_send(8'hA1, 3'b001, 1);
      rx_send(8'hA2, 3'b100, 1);
      chk(rx_req == 1'b1, "R10 at wm", rx_req, 1);
      rd_chk(RA_STAT, 8'h20, 8'h20, "R10 status bit");
      rx_send(8'hA3, 3'b000, 1);
      rx_send(8'hA4, 3'b010, 0);
      rd_chk(RA_RXCNT, 8'hFF, 8'h04, "R5 rxcnt full");
      rd_chk(RA_FSTAT, 8'hFF, 8'h84, "R5 rx overflow event");
      rd_chk(RA_STAT, 8'h0F, 8'h08, "R5 overrun R12 clean head");
      rx_take();
      rd_chk(RA_STAT, 8'h0F, 8'h01, "R13 overrun cleared R12 parity head");
      rx_take();
      rx_take();
      rd_chk(RA_STAT, 8'h0F, 8'h04, "R13 unarmed read keeps noise");
      rx_take();
      rd_chk(RA_STAT, 8'h0F, 8'h00, "R13 sequence clears");
      begin
         logic [7:0] d;
         rd(RA_DATA, d);
      end
      rd_chk(RA_FSTAT, 8'hFF, 8'hC5, "R6 rx underflow");
      wr(RA_FSTAT, 8'h05);
      rd_chk(RA_FSTAT, 8'hFF, 8'hC0, "R7 w1c rx bits");

      // R13 overrun survives an unarmed data read
      wr(RA_RXWM, 8'h01);
      rx_send(8'hB0, 3'b000, 1); rx_send(8'hB1, 3'b000, 1);
      rx_send(8'hB2, 3'b000, 1); rx_send(8'hB3, 3'b000, 1);
      rx_send(8'hB4, 3'b000, 0);
      rx_take();
      rd_chk(RA_STAT, 8'h08, 8'h08, "R13 overrun kept");

      // R8 receive flush
      wr(RA_FCTRL, 8'h47);
      rx_exp.delete();
      rd_chk(RA_RXCNT, 8'hFF, 8'h00, "R8 rx flush");
      chk(rx_req == 1'b0, "R10 empty", rx_req, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule